// File: doc/BRIEF.md
# Eight-Channel DAC Command Decoder

This block is the digital control core of an eight-channel serial digital-to-analog converter. A host sends 32-bit command words over a three-wire serial link: a clock, an active-low frame strobe and a data line. The block samples these pins in its own system clock domain and collects the bits. When the frame strobe is released after a complete word, the block decodes the word. Each channel has an input buffer and an output code register. The output codes are presented as parallel words to the analog converter stages.

Beyond plain channel writes and loads, the block holds a two-bit clear code. The clear code decides what the active-low clear pin does to every channel output: force zero scale, force midscale, force full scale, or nothing at all. A software reset command returns every register to its power-on value. The hardware reset input does the same. A build-time parameter selects whether the power-on code is zero scale or midscale.

Top module: `dacCmdCore`

## Requirements
- R1: Bits are taken MSB first on each falling edge of `sclk` while `syncN` is low. A word executes only when `syncN` rises after exactly 32 bits. A shorter or longer frame changes no state.
- R2: A word with bit 31 set is ignored. A command code in bits 27..24 other than 0000, 0001, 0010, 0011, 0101 and 0111 is also ignored. Bits 30..28 are don't-care.
- R3: Command 0000 writes the data field into the input buffer of the addressed channel, and leaves every output unchanged.
- R4: Command 0001 copies the addressed channel's input buffer into its output code. The address sits in bits 23..20. Addresses 0..7 select one channel, address 15 selects all eight channels, and addresses 8..14 select none.
- R5: Command 0011 writes the addressed channel's buffer and its output with the data at once. Command 0010 writes the addressed buffer and then loads every output from its buffer, so the new value is included.
- R6: Command 0101 loads the clear code from bits 1..0. The rest of that word has no effect.
- R7: While `clrN` is low and the clear code is 00, 01 or 10, every output shows zero scale (0x0000), midscale (0x8000) or full scale (0xFFFF) respectively, with no clock needed. The output registers keep that value after release, and the input buffers are unaffected.
- R8: With clear code 11, `clrN` has no effect on any output, and loads still take place while it is low.
- R9: Command 0111 sets every buffer and every output to the power-on code, and sets the clear code back to 00.
- R10: `rstN` low has the same effect as R9. The power-on code is 0x0000 when `RESET_MID` is 0 and 0x8000 when it is 1.
- R11: Channel data is taken left-justified from bits 19 down to 20-`DATA_W`. The feature bits 3..0 never reach a channel value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rstN | input | 1 | Active-low asynchronous hardware reset |
| sclk | input | 1 | Serial bit clock; data is taken on its falling edge |
| syncN | input | 1 | Active-low frame strobe; its rising edge executes the word |
| sdin | input | 1 | Serial data, MSB first |
| clrN | input | 1 | Active-low clear pin, acting through the clear code |
| dacCode | output | 8*DATA_W | Channel output codes; channel n occupies bits n*DATA_W and up |

## Verification
The bench sweeps all sixteen command codes against all sixteen addresses. This exposes a decoder that lets an unused code or an out-of-range address through: such a design would overwrite a buffer or an output. The same sweep shows a load-all command that drops the buffer value written by its own word, and a broadcast address that reaches only one channel. Frames of 31 and 33 bits, and a word with bit 31 set, must leave the outputs as they were; a design that counts loosely would execute them. Each clear code is tried with the pin held low and then released, and the buffers are reloaded afterwards. This catches a clear that corrupts the buffers, or that is ignored or obeyed against the code, and a software reset that leaves the clear code in place; both the zero-scale and the midscale reset builds are checked.

// File: rtl/dacCmdPkg.sv
package dacCmdPkg;

  localparam int NUM_CH  = 8;
  localparam int FRAME_W = 32;

  localparam logic [3:0] CMD_WR_BUF    = 4'h0;
  localparam logic [3:0] CMD_LD_OUT    = 4'h1;
  localparam logic [3:0] CMD_WR_LD_ALL = 4'h2;
  localparam logic [3:0] CMD_WR_LD_ONE = 4'h3;
  localparam logic [3:0] CMD_SET_CLR   = 4'h5;
  localparam logic [3:0] CMD_SOFT_RST  = 4'h7;

  localparam logic [3:0] ADDR_ALL = 4'hF;

  localparam logic [1:0] CLR_ZERO   = 2'b00;
  localparam logic [1:0] CLR_MID    = 2'b01;
  localparam logic [1:0] CLR_FULL   = 2'b10;
  localparam logic [1:0] CLR_IGNORE = 2'b11;

  // strobes from the decoder to the datapath, valid for one clock
  typedef struct packed {
    logic [NUM_CH-1:0] bufWe;
    logic [NUM_CH-1:0] outLoad;
    logic              clrWe;
    logic              softRst;
  } ctrlStrobeT;

endpackage

// File: rtl/dacFrameRx.sv
module dacFrameRx
  import dacCmdPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclk,
  input  logic               syncN,
  input  logic               sdin,
  output logic               frameValid,
  output logic [FRAME_W-1:0] frameWord
);

  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [1:0]         sclkSync;
  logic [1:0]         syncSync;
  logic [1:0]         sdinSync;
  logic               sclkPrev;
  logic               syncPrev;
  logic [FRAME_W-1:0] shiftReg;
  logic [CNT_W-1:0]   bitCnt;
  logic               sclkFall;
  logic               syncRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= 2'b11;
      syncSync <= 2'b11;
      sdinSync <= 2'b00;
      sclkPrev <= 1'b1;
      syncPrev <= 1'b1;
    end else begin
      sclkSync <= {sclkSync[0], sclk};
      syncSync <= {syncSync[0], syncN};
      sdinSync <= {sdinSync[0], sdin};
      sclkPrev <= sclkSync[1];
      syncPrev <= syncSync[1];
    end
  end

  assign sclkFall = sclkPrev && !sclkSync[1];
  assign syncRise = !syncPrev && syncSync[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (syncSync[1]) begin
      bitCnt <= '0;
    end else if (sclkFall) begin
      shiftReg <= {shiftReg[FRAME_W-2:0], sdinSync[1]};
      if (bitCnt != CNT_W'(CNT_MAX)) bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameValid <= 1'b0;
      frameWord  <= '0;
    end else begin
      frameValid <= syncRise && (bitCnt == CNT_W'(FRAME_W));
      if (syncRise) frameWord <= shiftReg;
    end
  end

endmodule

// File: rtl/dacCmdCtrl.sv
module dacCmdCtrl
  import dacCmdPkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic               frameValid,
  input  logic [FRAME_W-1:0] frameWord,
  output ctrlStrobeT         strobe,
  output logic [DATA_W-1:0]  wrData,
  output logic [1:0]         clrCodeNew
);

  localparam int DATA_MSB = 19;
  localparam int DATA_LSB = DATA_MSB - DATA_W + 1;

  logic [3:0]        cmdField;
  logic [3:0]        addrField;
  logic [NUM_CH-1:0] chanMask;
  logic              unusedFields;

  assign cmdField     = frameWord[27:24];
  assign addrField    = frameWord[23:20];
  assign wrData       = frameWord[DATA_MSB:DATA_LSB];
  assign clrCodeNew   = frameWord[1:0];
  assign unusedFields = ^{frameWord[30:28], frameWord[19:0]};

  always_comb begin
    for (int ch = 0; ch < NUM_CH; ch++) begin
      chanMask[ch] = (addrField == 4'(ch)) || (addrField == ADDR_ALL);
    end
  end

  always_comb begin
    strobe = '0;
    if (frameValid && !frameWord[FRAME_W-1]) begin
      case (cmdField)
        CMD_WR_BUF: strobe.bufWe = chanMask;
        CMD_LD_OUT: strobe.outLoad = chanMask;
        CMD_WR_LD_ALL: begin
          strobe.bufWe   = chanMask;
          strobe.outLoad = '1;
        end
        CMD_WR_LD_ONE: begin
          strobe.bufWe   = chanMask;
          strobe.outLoad = chanMask;
        end
        CMD_SET_CLR:  strobe.clrWe   = 1'b1;
        CMD_SOFT_RST: strobe.softRst = 1'b1;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/dacDatapath.sv
module dacDatapath
  import dacCmdPkg::*;
#(
  parameter int DATA_W    = 16,
  parameter bit RESET_MID = 1'b0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     clrN,
  input  ctrlStrobeT               strobe,
  input  logic [DATA_W-1:0]        wrData,
  input  logic [1:0]               clrCodeNew,
  output logic [1:0]               clrCodeCur,
  output logic [NUM_CH*DATA_W-1:0] dacCode
);

  localparam logic [DATA_W-1:0] CODE_ZERO = '0;
  localparam logic [DATA_W-1:0] CODE_FULL = '1;
  localparam logic [DATA_W-1:0] CODE_MID  = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] RST_CODE  = RESET_MID ? CODE_MID : CODE_ZERO;

  logic [DATA_W-1:0] clrVal;
  logic              clrActive;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              clrCodeCur <= CLR_ZERO;
    else if (strobe.softRst) clrCodeCur <= CLR_ZERO;
    else if (strobe.clrWe)   clrCodeCur <= clrCodeNew;
  end

  always_comb begin
    case (clrCodeCur)
      CLR_MID:  clrVal = CODE_MID;
      CLR_FULL: clrVal = CODE_FULL;
      default:  clrVal = CODE_ZERO;
    endcase
  end

  assign clrActive = !clrN && (clrCodeCur != CLR_IGNORE);

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    logic [DATA_W-1:0] bufReg;
    logic [DATA_W-1:0] outReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        bufReg <= RST_CODE;
        outReg <= RST_CODE;
      end else if (strobe.softRst) begin
        bufReg <= RST_CODE;
        outReg <= RST_CODE;
      end else begin
        if (strobe.bufWe[ch]) bufReg <= wrData;
        if (clrActive)                outReg <= clrVal;
        else if (strobe.outLoad[ch])  outReg <= strobe.bufWe[ch] ? wrData : bufReg;
      end
    end

    assign dacCode[ch*DATA_W +: DATA_W] = clrActive ? clrVal : outReg;
  end

endmodule

// File: rtl/dacCmdCore.sv
module dacCmdCore
  import dacCmdPkg::*;
#(
  parameter int DATA_W    = 16,
  parameter bit RESET_MID = 1'b0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     sclk,
  input  logic                     syncN,
  input  logic                     sdin,
  input  logic                     clrN,
  output logic [NUM_CH*DATA_W-1:0] dacCode
);

  logic               frameValid;
  logic [FRAME_W-1:0] frameWord;
  ctrlStrobeT         strobe;
  logic [DATA_W-1:0]  wrData;
  logic [1:0]         clrCodeNew;
  logic [1:0]         clrCodeCur;

  dacFrameRx u_rx (
    .clk(clk), .rstN(rstN), .sclk(sclk), .syncN(syncN), .sdin(sdin),
    .frameValid(frameValid), .frameWord(frameWord)
  );

  dacCmdCtrl #(.DATA_W(DATA_W)) u_ctrl (
    .frameValid(frameValid), .frameWord(frameWord),
    .strobe(strobe), .wrData(wrData), .clrCodeNew(clrCodeNew)
  );

  dacDatapath #(.DATA_W(DATA_W), .RESET_MID(RESET_MID)) u_dp (
    .clk(clk), .rstN(rstN), .clrN(clrN), .strobe(strobe),
    .wrData(wrData), .clrCodeNew(clrCodeNew),
    .clrCodeCur(clrCodeCur), .dacCode(dacCode)
  );

endmodule

// File: rtl/dacCmdChecker.sv
module dacCmdChecker
  import dacCmdPkg::*;
#(
  parameter int DATA_W    = 16,
  parameter bit RESET_MID = 1'b0
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     clrN,
  input logic [NUM_CH*DATA_W-1:0] dacCode,
  input ctrlStrobeT               strobe,
  input logic [1:0]               clrCodeCur
);

  logic [DATA_W-1:0]        expClr;
  logic [DATA_W-1:0]        expRst;
  logic [NUM_CH*DATA_W-1:0] expClrAll;
  logic [NUM_CH*DATA_W-1:0] expRstAll;

  always_comb begin
    expClr = '0;
    if (clrCodeCur == 2'b01) expClr = DATA_W'(1) << (DATA_W - 1);
    if (clrCodeCur == 2'b10) expClr = ~(DATA_W'(0));
    expRst    = RESET_MID ? (DATA_W'(1) << (DATA_W - 1)) : DATA_W'(0);
    expClrAll = {NUM_CH{expClr}};
    expRstAll = {NUM_CH{expRst}};
  end

  AST_CLR_FORCES_ALL: assert property (@(posedge clk) disable iff (!rstN)
    (!clrN && clrCodeCur != 2'b11) |-> (dacCode == expClrAll)); // R7

  AST_CLR_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    (strobe == '0 && clrCodeCur == 2'b11) |=> $stable(dacCode)); // R8

  AST_CLRCODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clrWe && !strobe.softRst) |=> $stable(clrCodeCur)); // R6

  AST_SOFT_RESET_DEFAULT: assert property (@(posedge clk) disable iff (!rstN)
    strobe.softRst |=> ((clrCodeCur == 2'b00) && (!clrN || dacCode == expRstAll))); // R9

  AST_NO_LOAD_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.outLoad == '0 && !strobe.softRst && clrN) |=> (!clrN || $stable(dacCode))); // R3

  AST_BUF_SELECT: assert property (@(posedge clk) disable iff (!rstN)
    ($onehot0(strobe.bufWe) || (&strobe.bufWe))); // R4

endmodule

bind dacCmdCore dacCmdChecker #(.DATA_W(DATA_W), .RESET_MID(RESET_MID)) u_chk (
  .clk(clk), .rstN(rstN), .clrN(clrN), .dacCode(dacCode),
  .strobe(strobe), .clrCodeCur(clrCodeCur)
);

// File: tb/dacCmdCore_tb.sv
`timescale 1ns/1ps
module dacCmdCore_tb;

  localparam int NCH = 8;
  localparam int DW  = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b1;
  logic syncN = 1'b1;
  logic sdin = 1'b0;
  logic clrN = 1'b1;
  logic [NCH*DW-1:0] code0;
  logic [NCH*DW-1:0] code1;

  int checks = 0;
  int errors = 0;

  logic [15:0] mBuf [2][NCH];
  logic [15:0] mOut [2][NCH];
  logic [1:0]  mClr;

  always #2.5 clk = ~clk;

  dacCmdCore #(.DATA_W(DW), .RESET_MID(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .syncN(syncN), .sdin(sdin),
    .clrN(clrN), .dacCode(code0));

  dacCmdCore #(.DATA_W(DW), .RESET_MID(1'b1)) u_dutMid (
    .clk(clk), .rstN(rstN), .sclk(sclk), .syncN(syncN), .sdin(sdin),
    .clrN(clrN), .dacCode(code1));

  function automatic logic [15:0] defOf(input int k);
    return (k == 1) ? 16'h8000 : 16'h0000;
  endfunction

  function automatic logic [15:0] clrValOf(input logic [1:0] c);
    case (c)
      2'b01:   return 16'h8000;
      2'b10:   return 16'hFFFF;
      default: return 16'h0000;
    endcase
  endfunction

  task automatic modelReset();
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < NCH; i++) begin
        mBuf[k][i] = defOf(k);
        mOut[k][i] = defOf(k);
      end
    mClr = 2'b00;
  endtask

  task automatic modelApply(input logic b31, input logic [3:0] c, input logic [3:0] a,
                            input logic [15:0] d, input logic [3:0] f);
    logic [NCH-1:0] m;
    if (b31) return;
    for (int i = 0; i < NCH; i++) m[i] = (a == 4'(i)) || (a == 4'hF);
    for (int k = 0; k < 2; k++)
      for (int i = 0; i < NCH; i++) begin
        case (c)
          4'h0: if (m[i]) mBuf[k][i] = d;
          4'h1: if (m[i]) mOut[k][i] = mBuf[k][i];
          4'h2: begin
            if (m[i]) mBuf[k][i] = d;
            mOut[k][i] = mBuf[k][i];
          end
          4'h3: if (m[i]) begin
            mBuf[k][i] = d;
            mOut[k][i] = d;
          end
          4'h7: begin
            mBuf[k][i] = defOf(k);
            mOut[k][i] = defOf(k);
          end
          default: ;
        endcase
      end
    if (c == 4'h5) mClr = f[1:0];
    if (c == 4'h7) mClr = 2'b00;
  endtask

  task automatic shiftBits(input logic [63:0] w, input int n);
    @(negedge clk);
    syncN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdin = w[i];
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
      repeat (4) @(negedge clk);
    end
    sclk = 1'b1;
    repeat (2) @(negedge clk);
    syncN = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  task automatic doCmd(input logic b31, input logic [2:0] dc, input logic [3:0] c,
                       input logic [3:0] a, input logic [15:0] d, input logic [3:0] f);
    logic [31:0] w;
    w = {b31, dc, c, a, d, f};
    shiftBits({32'h0, w}, 32);
    modelApply(b31, c, a, d, f);
  endtask

  task automatic checkAll(input string tag);
    logic [NCH*DW-1:0] e0;
    logic [NCH*DW-1:0] e1;
    for (int i = 0; i < NCH; i++) begin
      e0[i*DW +: DW] = (!clrN && mClr != 2'b11) ? clrValOf(mClr) : mOut[0][i];
      e1[i*DW +: DW] = (!clrN && mClr != 2'b11) ? clrValOf(mClr) : mOut[1][i];
    end
    checks++;
    if (code0 !== e0) begin
      errors++;
      $display("FAIL %s zero-default act=%h exp=%h", tag, code0, e0);
    end
    checks++;
    if (code1 !== e1) begin
      errors++;
      $display("FAIL %s mid-default act=%h exp=%h", tag, code1, e1);
    end
  endtask

  task automatic clrLow();
    clrN = 1'b0;
    if (mClr != 2'b11)
      for (int k = 0; k < 2; k++)
        for (int i = 0; i < NCH; i++) mOut[k][i] = clrValOf(mClr);
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    string tg;
    logic [15:0] d;
    modelReset();
    repeat (5) @(negedge clk);
    checkAll("R10 reset in power-on code");
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    checkAll("R10 after reset release");

    // R11: left-justified data, feature bits and don't-care bits ignored
    doCmd(1'b0, 3'b111, 4'h3, 4'h2, 16'hBEEF, 4'hF);
    checkAll("R11 data field alignment");

    // R1: short and long frames discarded
    shiftBits({32'h0, 1'b0, 3'b000, 4'h3, 4'h0, 16'h1111, 4'h0} >> 1, 31);
    checkAll("R1 31-bit frame discarded");
    shiftBits({31'h0, 1'b0, 1'b0, 3'b000, 4'h3, 4'h1, 16'h2222, 4'h0}, 33);
    checkAll("R1 33-bit frame discarded");

    // R2: bit 31 set
    doCmd(1'b1, 3'b000, 4'h3, 4'hF, 16'h3333, 4'h0);
    checkAll("R2 bit31 frame ignored");

    // exhaustive sweep of command and address
    for (int c = 0; c < 16; c++) begin
      for (int a = 0; a < 16; a++) begin
        d = 16'h5A3C ^ {4'(c), 4'(a), 4'(a), 4'(c)};
        doCmd(1'b0, 3'(a), 4'(c), 4'(a), d, 4'(c) ^ 4'(a));
        case (c)
          0: tg = "R3 write buffer";
          1: tg = "R4 load output";
          2, 3: tg = "R5 write and load";
          5: tg = "R6 clear code write";
          7: tg = "R9 software reset";
          default: tg = "R2 unsupported code";
        endcase
        checkAll(tg);
      end
    end

    // R7: each forcing clear code, buffers preserved
    for (int cc = 0; cc < 3; cc++) begin
      doCmd(1'b0, 3'b000, 4'h0, 4'hF, 16'h4321 + 16'(cc), 4'h0);
      doCmd(1'b0, 3'b000, 4'h0, 4'h3, 16'h0F0F, 4'h0);
      doCmd(1'b0, 3'b000, 4'h1, 4'hF, 16'h0000, 4'h0);
      doCmd(1'b0, 3'b000, 4'h5, 4'h0, 16'hFFFF, 4'(cc));
      clrLow();
      checkAll("R7 clear pin low forces code");
      clrN = 1'b1;
      repeat (3) @(negedge clk);
      checkAll("R7 outputs hold cleared value");
      doCmd(1'b0, 3'b000, 4'h1, 4'hF, 16'h0000, 4'h0);
      checkAll("R7 buffers kept through clear");
    end

    // R8: clear ignored with code 11, loads still happen
    doCmd(1'b0, 3'b000, 4'h5, 4'h0, 16'h0000, 4'h3);
    clrLow();
    checkAll("R8 clear pin ignored");
    doCmd(1'b0, 3'b000, 4'h3, 4'h5, 16'h9876, 4'h0);
    checkAll("R8 load while clear pin low");
    clrN = 1'b1;
    repeat (3) @(negedge clk);
    checkAll("R8 release changes nothing");

    // R9: software reset returns clear code to 00
    doCmd(1'b0, 3'b000, 4'h5, 4'h0, 16'h0000, 4'h2);
    doCmd(1'b0, 3'b000, 4'h7, 4'h0, 16'hABCD, 4'hF);
    checkAll("R9 software reset defaults");
    clrLow();
    checkAll("R9 clear code back to zero scale");
    clrN = 1'b1;
    repeat (3) @(negedge clk);

    // R10: hardware reset
    doCmd(1'b0, 3'b000, 4'h3, 4'hF, 16'h7777, 4'h0);
    doCmd(1'b0, 3'b000, 4'h5, 4'h0, 16'h0000, 4'h1);
    rstN = 1'b0;
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkAll("R10 hardware reset defaults");
    clrLow();
    checkAll("R10 clear code zero after hardware reset");
    clrN = 1'b1;
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule